// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the floating-point status and control register that sits beside an arithmetic datapath. Each time the datapath finishes an operation it raises a completion strobe and reports five raw exception indications: invalid, divide-by-zero, overflow, underflow and inexact. The block records them in a cause field that is rewritten by every operation. It also ORs them into a sticky flag field. If any reported condition is enabled in the enable field, it issues a one-cycle exception request that carries a fixed vector code.

An operation tagged as an approximate reciprocal square root always counts as inexact when it reports nothing else. Software may overwrite the register at any time. The stored value passes through a fixed writable-bit mask, and a write always beats an operation completing in the same cycle. The block decodes two controls from the register for the datapath: the rounding selection and the denormal flush enable.

Top module: `fpu_status_ctrl`

## Requirements
- R1: While reset is asserted, the register reads 0, the exception request is low and its code is 0.
- R2: A software write stores the write data ANDed with 0x0005_FFFF. When a write and an operation completion arrive in the same cycle, the write is kept and the operation has no effect on the register and raises no request.
- R3: On each operation completion, the cause field (bits 16:12) is replaced by that operation's effective exception set. The raw input order is bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid, and the field keeps the same order from bit 12 upward.
- R4: An operation with an empty effective exception set clears the cause field, leaves the flag field unchanged and raises no request.
- R5: Flag bits 6:2, in the same order as the cause bits, accumulate the effective exceptions of every operation. Only a software write clears them.
- R6: When the effective exceptions ANDed with the enable bits 11:7 (same order) are nonzero, the exception request is high for the single cycle after the completion, with code 0x120. At all other times the request is low and the code is 0.
- R7: With the approximation tag set and no raw exception reported, the effective set is inexact alone. With any raw exception reported, the effective set equals the raw set.
- R8: The round-toward-zero output is high exactly when register bits 1:0 equal 01; any other value selects round-to-nearest-even.
- R9: The denormal flush output follows register bit 18.
- R10: Register bit 17, the unimplemented-operation cause bit, always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| op_done_i | input | 1 | Operation completion strobe |
| op_exc_i | input | 5 | Raw exceptions {V,Z,O,U,I} |
| op_approx_i | input | 1 | Completing operation is an approximate reciprocal square root |
| csr_o | output | 32 | Current register value |
| round_to_zero_o | output | 1 | 1: round toward zero, 0: round to nearest even |
| flush_denorm_o | output | 1 | Denormal flush-to-zero enable |
| trap_o | output | 1 | Exception request pulse |
| trap_code_o | output | 12 | Vector code of the request |

## Verification
A write or an operation presented before a rising edge shows up in the register one cycle later, at that edge. The exception request and its code are registered from the same edge, so they are also due exactly one cycle after the completion. The rounding and flush outputs are plain decodes of the register and follow it in the same cycle. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It then compares every output one nanosecond later, so each result is checked in the cycle it becomes due and not before.

// File: rtl/fpu_status_pkg.sv
package fpu_status_pkg;
  localparam int unsigned CSR_W      = 32;
  localparam int unsigned N_EXC      = 5;
  localparam int unsigned RM_LSB     = 0;
  localparam int unsigned RM_W       = 2;
  localparam int unsigned FLAG_LSB   = 2;
  localparam int unsigned EN_LSB     = FLAG_LSB + N_EXC;
  localparam int unsigned CAUSE_LSB  = EN_LSB + N_EXC;
  localparam int unsigned UNIMPL_BIT = CAUSE_LSB + N_EXC;
  localparam int unsigned DENORM_BIT = UNIMPL_BIT + 1;
  localparam int unsigned CODE_W     = 12;

  localparam logic [CSR_W-1:0]  WR_MASK   = 32'h0005_FFFF;
  localparam logic [RM_W-1:0]   RM_ZERO   = 2'b01;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

  typedef enum int unsigned {
    EXC_I = 0,
    EXC_U = 1,
    EXC_O = 2,
    EXC_Z = 3,
    EXC_V = 4
  } exc_idx_e;
endpackage

// File: rtl/fpu_exc_merge.sv
module fpu_exc_merge
  import fpu_status_pkg::*;
#(
  parameter int unsigned NE = N_EXC
) (
  input  logic [NE-1:0] raw_i,
  input  logic          approx_i,
  output logic [NE-1:0] eff_o,
  output logic          any_o
);
  always_comb begin
    eff_o = raw_i;
    // approximation result is inexact unless something stronger was reported
    if (approx_i && (raw_i == '0)) eff_o[EXC_I] = 1'b1;
    any_o = (eff_o != '0);
  end
endmodule

// File: rtl/fpu_csr_reg.sv
module fpu_csr_reg
  import fpu_status_pkg::*;
#(
  parameter int unsigned  W    = CSR_W,
  parameter int unsigned  NE   = N_EXC,
  parameter logic [W-1:0] MASK = WR_MASK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          op_done_i,
  input  logic [NE-1:0] eff_i,
  input  logic          any_i,
  output logic [W-1:0]  csr_o
);
  logic [W-1:0] csr_q, csr_d;

  always_comb begin
    csr_d = csr_q;
    if (wr_en_i) begin
      csr_d = wr_data_i & MASK;
    end else if (op_done_i) begin
      csr_d[CAUSE_LSB +: NE+1] = '0;
      if (any_i) begin
        csr_d[CAUSE_LSB +: NE] = eff_i;
        csr_d[FLAG_LSB +: NE]  = csr_q[FLAG_LSB +: NE] | eff_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= '0;
    else         csr_q <= csr_d;
  end

  assign csr_o = csr_q;
endmodule

// File: rtl/fpu_trap_gen.sv
module fpu_trap_gen
  import fpu_status_pkg::*;
#(
  parameter int unsigned       NE   = N_EXC,
  parameter int unsigned       CW   = CODE_W,
  parameter logic [CW-1:0]     CODE = TRAP_CODE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [NE-1:0] eff_i,
  input  logic [NE-1:0] enable_i,
  output logic          trap_o,
  output logic [CW-1:0] code_o
);
  logic hit;
  assign hit = fire_i && ((eff_i & enable_i) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o <= 1'b0;
      code_o <= '0;
    end else begin
      trap_o <= hit;
      code_o <= hit ? CODE : '0;
    end
  end
endmodule

// File: rtl/fpu_status_ctrl.sv
module fpu_status_ctrl
  import fpu_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CSR_W-1:0]  wr_data_i,
  input  logic              op_done_i,
  input  logic [N_EXC-1:0]  op_exc_i,
  input  logic              op_approx_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic              round_to_zero_o,
  output logic              flush_denorm_o,
  output logic              trap_o,
  output logic [CODE_W-1:0] trap_code_o
);
  logic [N_EXC-1:0] eff;
  logic             any_exc;
  logic             fire;

  fpu_exc_merge #(.NE(N_EXC)) u_merge (
    .raw_i    (op_exc_i),
    .approx_i (op_approx_i),
    .eff_o    (eff),
    .any_o    (any_exc)
  );

  fpu_csr_reg #(.W(CSR_W), .NE(N_EXC), .MASK(WR_MASK)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .op_done_i (op_done_i),
    .eff_i     (eff),
    .any_i     (any_exc),
    .csr_o     (csr_o)
  );

  // software write wins over a completing operation
  assign fire = op_done_i && !wr_en_i;

  fpu_trap_gen #(.NE(N_EXC), .CW(CODE_W), .CODE(TRAP_CODE)) u_trap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .eff_i    (eff),
    .enable_i (csr_o[EN_LSB +: N_EXC]),
    .trap_o   (trap_o),
    .code_o   (trap_code_o)
  );

  assign round_to_zero_o = (csr_o[RM_LSB +: RM_W] == RM_ZERO);
  assign flush_denorm_o  = csr_o[DENORM_BIT];
endmodule

// File: rtl/fpu_status_ctrl_chk.sv
module fpu_status_ctrl_chk
  import fpu_status_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [CSR_W-1:0]  wr_data_i,
  input logic              op_done_i,
  input logic [N_EXC-1:0]  op_exc_i,
  input logic              op_approx_i,
  input logic [CSR_W-1:0]  csr_o,
  input logic              round_to_zero_o,
  input logic              flush_denorm_o,
  input logic              trap_o,
  input logic [CODE_W-1:0] trap_code_o
);
  AST_WRITE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (csr_o == ($past(wr_data_i) & WR_MASK))); // R2

  AST_QUIET_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && !wr_en_i && (op_exc_i == '0) && !op_approx_i) |=>
      ((csr_o[CAUSE_LSB +: N_EXC] == '0) &&
       (csr_o[FLAG_LSB +: N_EXC] == $past(csr_o[FLAG_LSB +: N_EXC])) && !trap_o)); // R4

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((csr_o[FLAG_LSB +: N_EXC] & $past(csr_o[FLAG_LSB +: N_EXC]))
                  == $past(csr_o[FLAG_LSB +: N_EXC]))); // R5

  AST_TRAP_FROM_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_done_i && !wr_en_i)); // R6

  AST_TRAP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_code_o == (trap_o ? TRAP_CODE : '0)); // R6

  AST_APPROX_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && !wr_en_i && (op_exc_i == '0) && op_approx_i) |=>
      (csr_o[CAUSE_LSB +: N_EXC] == 5'b00001)); // R7

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_o[UNIMPL_BIT]); // R10
endmodule

bind fpu_status_ctrl fpu_status_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .op_done_i       (op_done_i),
  .op_exc_i        (op_exc_i),
  .op_approx_i     (op_approx_i),
  .csr_o           (csr_o),
  .round_to_zero_o (round_to_zero_o),
  .flush_denorm_o  (flush_denorm_o),
  .trap_o          (trap_o),
  .trap_code_o     (trap_code_o)
);

// File: tb/fpu_status_ctrl_bench.sv
module fpu_status_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        op_done_i = 1'b0;
  logic [4:0]  op_exc_i = '0;
  logic        op_approx_i = 1'b0;
  logic [31:0] csr_o;
  logic        round_to_zero_o, flush_denorm_o, trap_o;
  logic [11:0] trap_code_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_csr = '0;
  logic        m_trap = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpu_status_ctrl u_fpu_status_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .op_done_i, .op_exc_i,
    .op_approx_i, .csr_o, .round_to_zero_o, .flush_denorm_o, .trap_o,
    .trap_code_o
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all(input string csr_req);
    check(csr_req, csr_o, m_csr);
    check("R6 trap", {31'd0, trap_o}, {31'd0, m_trap});
    check("R6 code", {20'd0, trap_code_o}, m_trap ? 32'h120 : 32'h0);
    check("R8", {31'd0, round_to_zero_o}, {31'd0, m_csr[1:0] == 2'b01});
    check("R9", {31'd0, flush_denorm_o}, {31'd0, m_csr[18]});
    check("R10", {31'd0, csr_o[17]}, 32'd0);
  endtask

  // one cycle: drive on falling edge, model at rising edge, compare just after
  task automatic step(input string req, input logic we, input logic [31:0] wd,
                      input logic done, input logic [4:0] exc, input logic apx);
    logic [4:0] eff;
    @(negedge clk_i);
    wr_en_i = we; wr_data_i = wd; op_done_i = done; op_exc_i = exc; op_approx_i = apx;
    @(posedge clk_i);
    m_trap = 1'b0;
    if (we) begin
      m_csr = wd & 32'h0005_FFFF;
    end else if (done) begin
      eff = exc;
      if (apx && exc == 5'd0) eff = 5'b00001;
      m_csr[17:12] = 6'd0;
      if (eff != 5'd0) begin
        m_csr[16:12] = eff;
        m_csr[6:2]   = m_csr[6:2] | eff;
        m_trap       = (eff & m_csr[11:7]) != 5'd0;
      end
    end
    #1;
    compare_all(req);
  endtask

  task automatic idle();
    step("R6 idle", 1'b0, 32'd0, 1'b0, 5'd0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #1;
    compare_all("R1");                                // reset state
    @(negedge clk_i);
    rst_ni = 1'b1;

    step("R2", 1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0); // mask, bit17 cleared (R10), R9
    step("R8", 1'b1, 32'h0000_0001, 1'b0, 5'd0, 1'b0); // round toward zero
    step("R8", 1'b1, 32'h0000_0002, 1'b0, 5'd0, 1'b0); // other mode
    step("R9", 1'b1, 32'h0004_0000, 1'b0, 5'd0, 1'b0); // flush on
    step("R3", 1'b0, 32'd0, 1'b1, 5'b10000, 1'b0);     // invalid
    step("R3", 1'b0, 32'd0, 1'b1, 5'b00001, 1'b0);     // cause rewritten to inexact
    step("R5", 1'b0, 32'd0, 1'b1, 5'b00100, 1'b0);     // flags accumulate
    step("R4", 1'b0, 32'd0, 1'b1, 5'b00000, 1'b0);     // empty: cause cleared, flags kept
    step("R7", 1'b0, 32'd0, 1'b1, 5'b00000, 1'b1);     // approx forces inexact
    step("R7", 1'b0, 32'd0, 1'b1, 5'b00100, 1'b1);     // approx with overflow only
    step("R6", 1'b1, 32'h0000_0400, 1'b0, 5'd0, 1'b0); // enable divide-by-zero
    step("R6", 1'b0, 32'd0, 1'b1, 5'b01000, 1'b0);     // trap pulse
    idle();                                            // pulse ends
    step("R6", 1'b0, 32'd0, 1'b1, 5'b00100, 1'b0);     // not enabled: no trap
    step("R6", 1'b0, 32'd0, 1'b1, 5'b01000, 1'b0);     // back-to-back traps
    step("R6", 1'b0, 32'd0, 1'b1, 5'b01001, 1'b0);
    step("R2", 1'b1, 32'h0000_0400, 1'b1, 5'b01000, 1'b0); // write wins, no trap
    step("R4", 1'b0, 32'd0, 1'b1, 5'b00000, 1'b0);     // no trap on empty op
    step("R6", 1'b1, 32'h0000_0F80, 1'b0, 5'd0, 1'b0); // all enabled
    step("R7", 1'b0, 32'd0, 1'b1, 5'b00000, 1'b1);     // forced inexact traps
    idle();

    for (int i = 0; i < 300; i++) begin
      logic        we  = ($urandom % 8) == 0;
      logic        dn  = ($urandom % 2) == 0;
      logic        apx = ($urandom % 4) == 0;
      logic [4:0]  ex  = (($urandom % 3) == 0) ? 5'd0 : 5'($urandom);
      logic [31:0] wd  = $urandom;
      step("R3", we, wd, dn, ex, apx);
    end
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule